// File: doc/BRIEF.md
# Branch Condition and Next-PC Selector

This combinational block sits in the execute stage of a single-issue integer core. It compares the two source register values, reports whether they are equal and whether the first is below the second, and decides whether the instruction in flight redirects the fetch stream. When there is a redirect, the next program counter is a target that the ALU has already computed. Otherwise the next program counter is the current PC plus one instruction width.

The six conditional branches reduce to two flags: equality and less-than. Bit 1 of the branch function code makes less-than compare as unsigned numbers instead of two's-complement numbers. The greater-or-equal branches are taken when less-than is false.

An instruction class input tells the block what to do:
- a plain sequential instruction (no redirect),
- a conditional branch (decided from the flags),
- a direct jump (always taken, target used as is),
- a register-indirect jump (always taken, target bit 0 cleared).

Top module: `branch_next_pc`

## Requirements
- R1: `eq_o` is 1 exactly when `src_a` equals `src_b`, whatever the class and function code.
- R2: `lt_o` gives `src_a < src_b`. The compare is signed two's-complement when `funct3_i[1]` is 0 and unsigned when it is 1. `lt_o` is never 1 together with `eq_o`.
- R3: With class 01 (conditional branch), function code 000 is taken when `eq_o` is 1, and code 001 is taken when `eq_o` is 0.
- R4: With class 01, code 100 is taken on signed less-than and code 101 is taken on signed not-less-than. Equal operands therefore take 101.
- R5: With class 01, code 110 is taken on unsigned less-than and code 111 is taken on unsigned not-less-than. Equal operands take 111. 0x80000000 against 0x7FFFFFFF orders oppositely under R4 and R5.
- R6: With class 01, codes 010 and 011 are never taken.
- R7: Whenever `taken_o` is 0, `next_pc_o` is `pc_i + 4`, wrapping modulo 2^32.
- R8: A taken conditional branch drives `next_pc_o` with `target_i` unchanged.
- R9: Class 10 (direct jump) is always taken and drives `next_pc_o` with `target_i` unchanged, odd bits included, regardless of the flags.
- R10: Class 11 (indirect jump) is always taken and drives `next_pc_o` with `target_i` with bit 0 forced to 0.
- R11: Class 00 (sequential) is never taken, whatever `funct3_i` and the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | 32 | First source register value |
| src_b | input | 32 | Second source register value |
| funct3_i | input | 3 | Branch function code |
| flow_class_i | input | 2 | 00 sequential, 01 conditional branch, 10 direct jump, 11 indirect jump |
| pc_i | input | 32 | Address of the current instruction |
| target_i | input | 32 | ALU-computed redirect address |
| eq_o | output | 1 | Operands equal |
| lt_o | output | 1 | First operand below second, signedness from `funct3_i[1]` |
| taken_o | output | 1 | Control flow redirects |
| next_pc_o | output | 32 | Address of the next instruction |

## Verification
The comparator flags and the jump redirect are active in the same evaluation. A jump is applied while its operands would also satisfy or fail a branch code: equal operands under an indirect jump, and unequal operands under a direct jump. The bench then checks two things at once. The flags must still match a signed or unsigned reference compare. The next PC must follow the jump rule, not the branch condition. The sequential class is also driven with a function code and operands that would take a branch, and the result must be PC plus four.

// File: rtl/branch_next_pc.sv
module branch_next_pc #(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [2:0]      funct3_i,
  input  logic [1:0]      flow_class_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] target_i,
  output logic            eq_o,
  output logic            lt_o,
  output logic            taken_o,
  output logic [XLEN-1:0] next_pc_o
);

  localparam logic [1:0] CLS_SEQ  = 2'b00;
  localparam logic [1:0] CLS_BR   = 2'b01;
  localparam logic [1:0] CLS_JMP  = 2'b10;
  localparam logic [1:0] CLS_JIND = 2'b11;

  localparam logic [2:0] F_EQ  = 3'b000;
  localparam logic [2:0] F_NE  = 3'b001;
  localparam logic [2:0] F_LT  = 3'b100;
  localparam logic [2:0] F_GE  = 3'b101;
  localparam logic [2:0] F_LTU = 3'b110;
  localparam logic [2:0] F_GEU = 3'b111;

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic            lt_signed;
  logic            lt_unsigned;
  logic            cond_met;
  logic [XLEN-1:0] seq_pc;

  assign eq_o        = (src_a == src_b);
  assign lt_unsigned = (src_a < src_b);
  assign lt_signed   = ($signed(src_a) < $signed(src_b));
  assign lt_o        = funct3_i[1] ? lt_unsigned : lt_signed;
  assign seq_pc      = pc_i + STEP;

  always_comb begin
    case (funct3_i)
      F_EQ:         cond_met = eq_o;
      F_NE:         cond_met = !eq_o;
      F_LT, F_LTU:  cond_met = lt_o;
      F_GE, F_GEU:  cond_met = !lt_o;
      default:      cond_met = 1'b0;
    endcase
  end

  always_comb begin
    case (flow_class_i)
      CLS_BR:   taken_o = cond_met;
      CLS_JMP:  taken_o = 1'b1;
      CLS_JIND: taken_o = 1'b1;
      default:  taken_o = 1'b0;
    endcase
  end

  always_comb begin
    if (!taken_o)
      next_pc_o = seq_pc;
    else if (flow_class_i == CLS_JIND)
      next_pc_o = {target_i[XLEN-1:1], 1'b0};
    else
      next_pc_o = target_i;
  end

  always_comb begin
    assert_eq_excludes_lt_R2: assert (!(eq_o && lt_o))
      else $error("eq and lt both set");
    assert_eq_matches_R1: assert (eq_o == (src_a == src_b))
      else $error("eq flag wrong");
    assert_jump_taken_R9: assert (!flow_class_i[1] || taken_o)
      else $error("jump not taken");
    assert_seq_never_taken_R11: assert (flow_class_i != CLS_SEQ || !taken_o)
      else $error("sequential class redirected");
    assert_reserved_codes_R6: assert (!(flow_class_i == CLS_BR && funct3_i[2:1] == 2'b01) || !taken_o)
      else $error("reserved code taken");
    assert_fallthrough_R7: assert (taken_o || next_pc_o == pc_i + STEP)
      else $error("fall-through address wrong");
    assert_indirect_even_R10: assert (flow_class_i != CLS_JIND ||
                                      (!next_pc_o[0] && next_pc_o[XLEN-1:1] == target_i[XLEN-1:1]))
      else $error("indirect target wrong");
    assert_branch_target_R8: assert (!(flow_class_i == CLS_BR && taken_o) || next_pc_o == target_i)
      else $error("branch target wrong");
    assert_lt_pair_R4: assert (!(flow_class_i == CLS_BR && funct3_i[2]) || (taken_o ^ funct3_i[0]) == lt_o)
      else $error("less-than pair inconsistent");
  end

endmodule

// File: tb/branch_next_pc_test.sv
module branch_next_pc_test;

  logic        clk = 1'b0;
  logic [31:0] src_a, src_b, pc_i, target_i;
  logic [2:0]  funct3_i;
  logic [1:0]  flow_class_i;
  logic        eq_o, lt_o, taken_o;
  logic [31:0] next_pc_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  branch_next_pc uut (
    .src_a(src_a), .src_b(src_b), .funct3_i(funct3_i), .flow_class_i(flow_class_i),
    .pc_i(pc_i), .target_i(target_i), .eq_o(eq_o), .lt_o(lt_o),
    .taken_o(taken_o), .next_pc_o(next_pc_o)
  );

  localparam int NV = 22;
  localparam logic [69:0] VEC [NV] = '{
    {32'h00000005, 32'h00000005, 3'b000, 2'b01, 1'b1},
    {32'h00000005, 32'h00000006, 3'b000, 2'b01, 1'b0},
    {32'h00000005, 32'h00000005, 3'b001, 2'b01, 1'b0},
    {32'h00000005, 32'h00000006, 3'b001, 2'b01, 1'b1},
    {32'h80000000, 32'h7FFFFFFF, 3'b100, 2'b01, 1'b1},
    {32'h80000000, 32'h7FFFFFFF, 3'b110, 2'b01, 1'b0},
    {32'h80000000, 32'h7FFFFFFF, 3'b101, 2'b01, 1'b0},
    {32'h80000000, 32'h7FFFFFFF, 3'b111, 2'b01, 1'b1},
    {32'h7FFFFFFF, 32'h80000000, 3'b100, 2'b01, 1'b0},
    {32'h7FFFFFFF, 32'h80000000, 3'b110, 2'b01, 1'b1},
    {32'h12345678, 32'h12345678, 3'b101, 2'b01, 1'b1},
    {32'h12345678, 32'h12345678, 3'b111, 2'b01, 1'b1},
    {32'hFFFFFFFF, 32'h00000001, 3'b100, 2'b01, 1'b1},
    {32'hFFFFFFFF, 32'h00000001, 3'b110, 2'b01, 1'b0},
    {32'h00000003, 32'h00000003, 3'b010, 2'b01, 1'b0},
    {32'h00000001, 32'h00000002, 3'b011, 2'b01, 1'b0},
    {32'h00000001, 32'h00000002, 3'b000, 2'b10, 1'b1},
    {32'h00000007, 32'h00000007, 3'b001, 2'b11, 1'b1},
    {32'h00000000, 32'h00000000, 3'b000, 2'b00, 1'b0},
    {32'h00000001, 32'h00000002, 3'b100, 2'b00, 1'b0},
    {32'h00000000, 32'hFFFFFFFF, 3'b111, 2'b01, 1'b0},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 3'b100, 2'b01, 1'b0}
  };

  function automatic string req_of(input logic [2:0] f, input logic [1:0] c);
    if (c == 2'b00) return "R11";
    if (c == 2'b10) return "R9";
    if (c == 2'b11) return "R10";
    case (f)
      3'b000, 3'b001: return "R3";
      3'b100, 3'b101: return "R4";
      3'b110, 3'b111: return "R5";
      default:        return "R6";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [2:0] f,
                       input logic [1:0] c, input logic [31:0] pc, input logic [31:0] tg);
    @(posedge clk);
    src_a = a; src_b = b; funct3_i = f; flow_class_i = c; pc_i = pc; target_i = tg;
    @(negedge clk);
  endtask

  task automatic check_flags(input logic [31:0] a, input logic [31:0] b, input logic [2:0] f);
    logic exp_lt;
    exp_lt = f[1] ? (a < b) : ($signed(a) < $signed(b));
    check("R1", "eq flag", {31'b0, eq_o}, {31'b0, a == b});
    check("R2", "lt flag", {31'b0, lt_o}, {31'b0, exp_lt});
  endtask

  initial begin
    src_a = '0; src_b = '0; funct3_i = '0; flow_class_i = '0; pc_i = '0; target_i = '0;
    @(negedge clk);
    // idle state: sequential class, zero operands
    check("R11", "idle taken", {31'b0, taken_o}, 32'd0);
    check("R7", "idle next pc", next_pc_o, 32'd4);
    check("R1", "idle eq", {31'b0, eq_o}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] a, b, pc, tg, exp_next;
      logic [2:0]  f;
      logic [1:0]  c;
      logic        tk;
      {a, b, f, c, tk} = VEC[i];
      pc = 32'h1000 + 32'(i) * 8;
      tg = 32'h2001 + 32'(i) * 16;
      apply(a, b, f, c, pc, tg);
      check_flags(a, b, f);
      check(req_of(f, c), "taken", {31'b0, taken_o}, {31'b0, tk});
      if (!tk)          exp_next = pc + 4;
      else if (c == 2'b11) exp_next = tg & ~32'd1;
      else              exp_next = tg;
      check(tk ? (c == 2'b01 ? "R8" : req_of(f, c)) : "R7", "next pc", next_pc_o, exp_next);
    end

    // R7: fall-through wraps at the top of the address space
    apply(32'd1, 32'd2, 3'b000, 2'b01, 32'hFFFFFFFC, 32'h00004000);
    check("R7", "wrap next pc", next_pc_o, 32'h00000000);
    // R10: even indirect target passes unchanged, odd target loses bit 0
    apply(32'd9, 32'd9, 3'b000, 2'b11, 32'h100, 32'h00008004);
    check("R10", "indirect even", next_pc_o, 32'h00008004);
    apply(32'd9, 32'd9, 3'b000, 2'b11, 32'h100, 32'hFFFFFFFF);
    check("R10", "indirect odd", next_pc_o, 32'hFFFFFFFE);
    check("R1", "eq during indirect jump", {31'b0, eq_o}, 32'd1);
    // R9: direct jump with a branch code that would not be taken
    apply(32'd3, 32'd4, 3'b000, 2'b10, 32'h200, 32'h00000333);
    check("R9", "direct jump taken", {31'b0, taken_o}, 32'd1);
    check("R9", "direct jump target", next_pc_o, 32'h00000333);
    // R11: sequential class with operands that satisfy BNE
    apply(32'd3, 32'd4, 3'b001, 2'b00, 32'h300, 32'h00000777);
    check("R11", "seq ignores branch", next_pc_o, 32'h00000304);
    // R5: unsigned bounds
    apply(32'hFFFFFFFF, 32'd0, 3'b111, 2'b01, 32'h400, 32'h500);
    check("R5", "bgeu max vs zero", {31'b0, taken_o}, 32'd1);
    check("R2", "unsigned lt false", {31'b0, lt_o}, 32'd0);
    apply(32'hFFFFFFFF, 32'd0, 3'b101, 2'b01, 32'h400, 32'h500);
    check("R4", "bge minus one vs zero", {31'b0, taken_o}, 32'd0);
    check("R2", "signed lt true", {31'b0, lt_o}, 32'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule